// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a small on-chip data cache placed between a processor word port and a plain main-memory port. A byte address is split into three fields: a tag, a set index and a word-in-block index. The block address modulo the number of sets selects one set. The two ways of that set compare their stored tags against the request in parallel. A hit completes in the cycle it is requested and returns the stored word. A miss fetches the whole block from memory one word per beat and then completes as a hit. Each set keeps one replacement bit that points at its least recently used way.

The write policy is fixed at elaboration by the `WRITE_BACK` parameter. With `WRITE_BACK=1`, the cache is write-back with write allocation. A write marks the line dirty, and a dirty line goes back to memory only when it is replaced. With `WRITE_BACK=0`, the cache is write-through with no write allocation. Every write becomes a single memory write beat, and a write miss leaves the cache untouched. The processor holds `cpuReq` until `cpuReady` rises, and the cache stalls it by keeping `cpuReady` low. Memory beats use a request/acknowledge pair in which the request is held until it is acknowledged.

Top module: `cache2w`

## Requirements
- R1: Address fields use the default geometry. Bits [31:6] are the tag, bits [5:4] select one of 4 sets, and bits [3:2] select one of 4 words in the block. Bits [1:0] are ignored because access is word-granular. Blocks in other sets are unaffected by an access.
- R2: A read hit raises `cpuReady` in the same cycle the request is presented. It returns the stored word on `cpuRdata` and makes no memory request.
- R3: After reset every line is invalid, so the first access to any block misses. A read miss issues four memory read beats at the block's word addresses in ascending order (offsets 0x0, 0x4, 0x8, 0xC). The read then completes with the addressed word.
- R4: A hit requires a valid line whose tag matches. Two blocks with different tags that map to the same set can both be resident and both hit.
- R5: On a miss, the fill goes into way 0 if way 0 is invalid, otherwise into way 1 if way 1 is invalid. If both ways are valid, the fill replaces the least recently used way. Every hit and every fill makes the accessed way the most recently used one.
- R6: In write-back mode, a write hit updates the cached word and marks the line dirty, with no memory traffic. A later read returns the new word.
- R7: In write-back mode, replacing a dirty line first writes its four words to its old block address as memory write beats, then fetches the new block. Replacing a clean line issues no write beats.
- R8: In write-back mode, a write miss fetches the block and then writes the word into it. Later reads of that block hit and return the written word.
- R9: In write-through mode, every write issues exactly one memory write beat carrying the word-aligned address and the data. The write completes in the cycle that beat is acknowledged. Lines are never dirty, so a replacement never writes back.
- R10: In write-through mode, a write hit also updates the cached word. A write miss leaves the cache unchanged, so a following read of that block misses.
- R11: Once raised, a memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Write word |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | 32 | Read word, valid with cpuReady on a read |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = memory write beat |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Memory write word |
| memAck | input | 1 | Beat acknowledge, read data valid with it |
| memRdata | input | 32 | Memory read word |

## Verification
The bench builds the cache twice with the default geometry of 4 sets and 4-word blocks. One instance uses `WRITE_BACK=1` and the other `WRITE_BACK=0`, so both write policies run side by side against their own memory models. With only two ways per set, a third tag in the same set forces a replacement within a handful of accesses. This makes the replacement order, clean versus dirty eviction, write allocation and no-write-allocation all observable through beat counts and returned words.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef struct packed {
    logic lruTouch;
    logic cpuWrite;
    logic fillWord;
    logic fillDone;
    logic latchVictim;
    logic evictSel;
    logic beatSel;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_THRU
  } ctrlState_t;

endpackage

// File: rtl/cache2w_dp.sv
module cache2w_dp
  import cache2w_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 4,
  parameter int SETS        = 4,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [$clog2(BLOCK_WORDS)-1:0] beat,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              victimDirty,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int WAYS     = 2;
  localparam int BYTE_OFS = $clog2(DATA_W / 8);
  localparam int WIDX     = $clog2(BLOCK_WORDS);
  localparam int SET_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - SET_W - WIDX - BYTE_OFS;

  logic [TAG_W-1:0]  tagMem   [SETS][WAYS];
  logic [DATA_W-1:0] dataMem  [SETS][WAYS][BLOCK_WORDS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];
  logic [SETS-1:0]   lruVec;

  logic [TAG_W-1:0] cpuTag;
  logic [SET_W-1:0] cpuSet;
  logic [WIDX-1:0]  cpuWord;
  logic [WAYS-1:0]  wayHit;
  logic             hitWay;
  logic             pickWay;
  logic             victimWay;
  logic             unusedByteBits;

  assign cpuTag         = cpuAddr[ADDR_W-1 -: TAG_W];
  assign cpuSet         = cpuAddr[BYTE_OFS+WIDX +: SET_W];
  assign cpuWord        = cpuAddr[BYTE_OFS +: WIDX];
  assign unusedByteBits = ^cpuAddr[BYTE_OFS-1:0];

  // Parallel tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wayHit[w] = validMem[cpuSet][w] && (tagMem[cpuSet][w] == cpuTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];
  assign rdata  = dataMem[cpuSet][hitWay][cpuWord];

  // Replacement choice: empty way 0, then empty way 1, else the LRU pointer
  always_comb begin
    if (!validMem[cpuSet][0])      pickWay = 1'b0;
    else if (!validMem[cpuSet][1]) pickWay = 1'b1;
    else                           pickWay = lruVec[cpuSet];
  end

  assign victimDirty = validMem[cpuSet][pickWay] && dirtyMem[cpuSet][pickWay];

  assign memAddr  = {strobe.evictSel ? tagMem[cpuSet][victimWay] : cpuTag,
                     cpuSet,
                     strobe.beatSel ? beat : cpuWord,
                     {BYTE_OFS{1'b0}}};
  assign memWdata = strobe.evictSel ? dataMem[cpuSet][victimWay][beat] : cpuWdata;

  // Line state: valid, dirty, tag, LRU
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
      end
      lruVec    <= '0;
      victimWay <= 1'b0;
    end else begin
      if (strobe.latchVictim) victimWay <= pickWay;
      if (strobe.lruTouch) lruVec[cpuSet] <= ~hitWay;
      if (strobe.cpuWrite && WRITE_BACK) dirtyMem[cpuSet][hitWay] <= 1'b1;
      if (strobe.fillDone) begin
        tagMem[cpuSet][victimWay]   <= cpuTag;
        validMem[cpuSet][victimWay] <= 1'b1;
        dirtyMem[cpuSet][victimWay] <= 1'b0;
        lruVec[cpuSet]              <= ~victimWay;
      end
    end
  end

  // Data words: no reset needed, guarded by valid
  always_ff @(posedge clk) begin
    if (strobe.fillWord)
      dataMem[cpuSet][victimWay][beat] <= memRdata;
    if (strobe.cpuWrite)
      dataMem[cpuSet][hitWay][cpuWord] <= cpuWdata;
  end

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int BLOCK_WORDS = 4,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cpuReq,
  input  logic      cpuWe,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic [$clog2(BLOCK_WORDS)-1:0] beat,
  output logic      cpuReady,
  output logic      memReq,
  output logic      memWe
);

  localparam int WIDX = $clog2(BLOCK_WORDS);

  ctrlState_t state, stateNext;
  logic       lastBeat;

  assign lastBeat = (beat == {WIDX{1'b1}});

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit && (!cpuWe || WRITE_BACK)) begin
            cpuReady        = 1'b1;
            strobe.lruTouch = 1'b1;
            strobe.cpuWrite = cpuWe;
          end else if (cpuWe && !WRITE_BACK) begin
            stateNext = ST_THRU;
          end else begin
            strobe.latchVictim = 1'b1;
            stateNext = victimDirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        memReq          = 1'b1;
        memWe           = 1'b1;
        strobe.evictSel = 1'b1;
        strobe.beatSel  = 1'b1;
        if (memAck && lastBeat) stateNext = ST_FILL;
      end
      ST_FILL: begin
        memReq         = 1'b1;
        strobe.beatSel = 1'b1;
        if (memAck) begin
          strobe.fillWord = 1'b1;
          if (lastBeat) begin
            strobe.fillDone = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      ST_THRU: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuReady        = 1'b1;
          strobe.cpuWrite = hit;
          strobe.lruTouch = hit;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      state <= stateNext;
      if (memAck && (state == ST_EVICT || state == ST_FILL))
        beat <= beat + 1'b1;
    end
  end

endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 4,
  parameter int SETS        = 4,
  parameter bit WRITE_BACK  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int WIDX = $clog2(BLOCK_WORDS);

  dpStrobe_t       strobe;
  logic [WIDX-1:0] beat;
  logic            hit;
  logic            victimDirty;

  cache2w_ctrl #(
    .BLOCK_WORDS(BLOCK_WORDS),
    .WRITE_BACK (WRITE_BACK)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAck     (memAck),
    .strobe     (strobe),
    .beat       (beat),
    .cpuReady   (cpuReady),
    .memReq     (memReq),
    .memWe      (memWe)
  );

  cache2w_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BLOCK_WORDS(BLOCK_WORDS),
    .SETS       (SETS),
    .WRITE_BACK (WRITE_BACK)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .beat       (beat),
    .memRdata   (memRdata),
    .hit        (hit),
    .victimDirty(victimDirty),
    .rdata      (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter bit WRITE_BACK = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  assert_read_no_traffic_R2: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && !cpuWe && cpuReady) |-> !memReq);

  assert_ready_with_req_R2: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuReq);

  assert_wb_done_local_R6: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK && cpuReady) |-> !memReq);

  assert_wt_write_beat_R9: assert property (@(posedge clk) disable iff (rst)
    (!WRITE_BACK && cpuReq && cpuWe && cpuReady) |-> (memReq && memWe && memAck));

  assert_wt_no_writeback_R9: assert property (@(posedge clk) disable iff (rst)
    (!WRITE_BACK && memReq && memWe && memAck) |-> cpuReady);

endmodule

bind cache2w cache2w_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuReady(cpuReady),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAck  (memAck),
  .memAddr (memAddr),
  .memWdata(memWdata)
);

// File: tb/test_cache2w.sv
`timescale 1ns/1ps

module test_cache2w_mem (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] store [logic [31:0]];

  always @(posedge clk) begin
    if (rst) begin
      ack <= 1'b0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) store[addr] = wdata;
      else rdata <= store.exists(addr) ? store[addr] : (32'hA500_0000 ^ addr);
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

module test_cache2w;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cpuReq   [2];
  logic        cpuWe    [2];
  logic [31:0] cpuAddr  [2];
  logic [31:0] cpuWdata [2];
  logic        cpuReady [2];
  logic [31:0] cpuRdata [2];
  logic        memReq   [2];
  logic        memWe    [2];
  logic [31:0] memAddr  [2];
  logic [31:0] memWdata [2];
  logic        memAck   [2];
  logic [31:0] memRdata [2];

  cache2w #(.WRITE_BACK(1'b1)) i_cache2w (
    .clk(clk), .rst(rst), .cpuReq(cpuReq[0]), .cpuWe(cpuWe[0]), .cpuAddr(cpuAddr[0]),
    .cpuWdata(cpuWdata[0]), .cpuReady(cpuReady[0]), .cpuRdata(cpuRdata[0]),
    .memReq(memReq[0]), .memWe(memWe[0]), .memAddr(memAddr[0]), .memWdata(memWdata[0]),
    .memAck(memAck[0]), .memRdata(memRdata[0]));

  cache2w #(.WRITE_BACK(1'b0)) i_cache2w_wt (
    .clk(clk), .rst(rst), .cpuReq(cpuReq[1]), .cpuWe(cpuWe[1]), .cpuAddr(cpuAddr[1]),
    .cpuWdata(cpuWdata[1]), .cpuReady(cpuReady[1]), .cpuRdata(cpuRdata[1]),
    .memReq(memReq[1]), .memWe(memWe[1]), .memAddr(memAddr[1]), .memWdata(memWdata[1]),
    .memAck(memAck[1]), .memRdata(memRdata[1]));

  test_cache2w_mem u_mem0 (.clk(clk), .rst(rst), .req(memReq[0]), .we(memWe[0]),
    .addr(memAddr[0]), .wdata(memWdata[0]), .ack(memAck[0]), .rdata(memRdata[0]));
  test_cache2w_mem u_mem1 (.clk(clk), .rst(rst), .req(memReq[1]), .we(memWe[1]),
    .addr(memAddr[1]), .wdata(memWdata[1]), .ack(memAck[1]), .rdata(memRdata[1]));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int lastWaits;
  int rdBeats [2];
  int wrBeats [2];
  int holdErr [2];
  bit wrAfterRd [2];
  bit pend [2];
  logic [31:0] pAddr [2];
  string curTag [2];
  logic [31:0] refMem [logic [32:0]];
  logic [31:0] expRd0 [$];
  logic [31:0] expRd1 [$];
  logic [63:0] expWr0 [$];
  logic [63:0] expWr1 [$];
  logic [31:0] rdLog [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refRead(input int m, input logic [31:0] a);
    logic [32:0] k;
    k = {m[0], a[31:2], 2'b00};
    return refMem.exists(k) ? refMem[k] : (32'hA500_0000 ^ {a[31:2], 2'b00});
  endfunction

  // Monitor: scoreboard compare away from the clock edge
  task automatic monitorStep(input int m);
    logic [31:0] e;
    logic [63:0] w;
    if (cpuReq[m] && cpuReady[m] && !cpuWe[m]) begin
      if (m == 0 && expRd0.size() > 0) begin
        e = expRd0.pop_front();
        check(cpuRdata[m] == e, curTag[m], "read data wb", cpuRdata[m], e);
      end else if (m == 1 && expRd1.size() > 0) begin
        e = expRd1.pop_front();
        check(cpuRdata[m] == e, curTag[m], "read data wt", cpuRdata[m], e);
      end else begin
        check(1'b0, curTag[m], "unexpected read completion", cpuRdata[m], 32'h0);
      end
    end
    if (memReq[m] && memAck[m]) begin
      if (memWe[m]) begin
        wrBeats[m]++;
        if (rdBeats[m] > 0) wrAfterRd[m] = 1'b1;
        if (m == 0 && expWr0.size() > 0) begin
          w = expWr0.pop_front();
          check({memAddr[m], memWdata[m]} == w, curTag[m], "write beat addr",
                memAddr[m], w[63:32]);
        end else if (m == 1 && expWr1.size() > 0) begin
          w = expWr1.pop_front();
          check({memAddr[m], memWdata[m]} == w, curTag[m], "write beat addr",
                memAddr[m], w[63:32]);
        end else begin
          check(1'b0, curTag[m], "unexpected write beat", memAddr[m], 32'h0);
        end
      end else begin
        rdBeats[m]++;
        if (m == 0) rdLog.push_back(memAddr[m]);
      end
    end
    if (pend[m] && (!memReq[m] || memAddr[m] != pAddr[m])) holdErr[m]++;
    pend[m]  = memReq[m] && !memAck[m];
    pAddr[m] = memAddr[m];
  endtask

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      monitorStep(0);
      monitorStep(1);
    end
  end

  // Driver: one processor access, expected read pushed into the scoreboard
  task automatic access(input int m, input bit we, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
    int waits;
    curTag[m] = tag;
    @(negedge clk);
    cpuReq[m] = 1'b1; cpuWe[m] = we; cpuAddr[m] = a; cpuWdata[m] = d;
    if (we) begin
      refMem[{m[0], a[31:2], 2'b00}] = d;
      if (m == 1) expWr1.push_back({a[31:2], 2'b00, d});
    end else if (m == 0) expRd0.push_back(refRead(m, a));
    else expRd1.push_back(refRead(m, a));
    #1;
    waits = 0;
    while (!cpuReady[m] && waits < 500) begin
      @(negedge clk); #1;
      waits++;
    end
    @(negedge clk);
    cpuReq[m] = 1'b0; cpuWe[m] = 1'b0;
    lastWaits = waits;
  endtask

  task automatic traffic(input int m, input int nr, input int nw, input string tag);
    check(rdBeats[m] == nr, tag, "read beats", rdBeats[m], nr);
    check(wrBeats[m] == nw, tag, "write beats", wrBeats[m], nw);
    rdBeats[m] = 0; wrBeats[m] = 0; wrAfterRd[m] = 1'b0;
    rdLog.delete();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      cpuReq[m] = 0; cpuWe[m] = 0; cpuAddr[m] = 0; cpuWdata[m] = 0;
      rdBeats[m] = 0; wrBeats[m] = 0; holdErr[m] = 0; pend[m] = 0;
      wrAfterRd[m] = 0; curTag[m] = "reset";
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    for (int m = 0; m < 2; m++) begin
      check(cpuReady[m] == 1'b0, "R3", "ready after reset", {31'b0, cpuReady[m]}, 0);
      check(memReq[m] == 1'b0, "R3", "memReq after reset", {31'b0, memReq[m]}, 0);
    end

    // ---------------- write-back instance ----------------
    access(0, 0, 32'h100, 0, "R3");
    check(lastWaits > 0, "R3", "first read stalls", lastWaits, 1);
    check(rdLog.size() == 4 && rdLog[0] == 32'h100 && rdLog[1] == 32'h104 &&
          rdLog[2] == 32'h108 && rdLog[3] == 32'h10C, "R3", "fill order start",
          rdLog.size() > 0 ? rdLog[0] : 32'hFFFF_FFFF, 32'h100);
    traffic(0, 4, 0, "R3");

    access(0, 0, 32'h108, 0, "R2");
    check(lastWaits == 0, "R2", "hit latency", lastWaits, 0);
    traffic(0, 0, 0, "R2");

    access(0, 0, 32'h140, 0, "R4");
    traffic(0, 4, 0, "R4");
    access(0, 0, 32'h14C, 0, "R4");
    access(0, 0, 32'h100, 0, "R4");
    traffic(0, 0, 0, "R4");

    access(0, 0, 32'h180, 0, "R5");
    traffic(0, 4, 0, "R5");
    access(0, 0, 32'h100, 0, "R5");
    traffic(0, 0, 0, "R5");
    access(0, 0, 32'h140, 0, "R5");
    traffic(0, 4, 0, "R5");

    access(0, 1, 32'h104, 32'hD1D1_0001, "R6");
    check(lastWaits == 0, "R6", "write hit latency", lastWaits, 0);
    access(0, 0, 32'h104, 0, "R6");
    traffic(0, 0, 0, "R6");

    access(0, 0, 32'h1C0, 0, "R7");
    traffic(0, 4, 0, "R7");
    for (int i = 0; i < 4; i++)
      expWr0.push_back({32'h100 + 32'(4 * i), refRead(0, 32'h100 + 32'(4 * i))});
    access(0, 0, 32'h200, 0, "R7");
    check(wrAfterRd[0] == 1'b0, "R7", "write-back precedes fill", {31'b0, wrAfterRd[0]}, 0);
    traffic(0, 4, 4, "R7");
    check(expWr0.size() == 0, "R7", "pending write beats", expWr0.size(), 0);
    access(0, 0, 32'h104, 0, "R7");
    traffic(0, 4, 0, "R7");

    access(0, 1, 32'h304, 32'hD2D2_0002, "R8");
    traffic(0, 4, 0, "R8");
    access(0, 0, 32'h304, 0, "R8");
    check(lastWaits == 0, "R8", "allocated read latency", lastWaits, 0);
    access(0, 0, 32'h308, 0, "R8");
    traffic(0, 0, 0, "R8");

    access(0, 0, 32'h307, 0, "R1");
    access(0, 0, 32'h014, 0, "R1");
    traffic(0, 4, 0, "R1");
    access(0, 0, 32'h010, 0, "R1");
    access(0, 0, 32'h100, 0, "R1");
    traffic(0, 0, 0, "R1");

    // ---------------- write-through instance ----------------
    access(1, 0, 32'h100, 0, "R3");
    traffic(1, 4, 0, "R3");
    access(1, 1, 32'h104, 32'hD3D3_0003, "R9");
    check(lastWaits > 0, "R9", "write waits for ack", lastWaits, 1);
    traffic(1, 0, 1, "R9");
    access(1, 0, 32'h104, 0, "R10");
    check(lastWaits == 0, "R10", "updated word hits", lastWaits, 0);
    traffic(1, 0, 0, "R10");
    access(1, 1, 32'h500, 32'hD4D4_0004, "R10");
    traffic(1, 0, 1, "R10");
    access(1, 0, 32'h500, 0, "R10");
    traffic(1, 4, 0, "R10");
    access(1, 0, 32'h600, 0, "R9");
    traffic(1, 4, 0, "R9");
    check(expWr1.size() == 0, "R9", "pending write beats", expWr1.size(), 0);

    check(holdErr[0] == 0 && holdErr[1] == 0, "R11", "request hold violations",
          holdErr[0] + holdErr[1], 0);
    check(expRd0.size() == 0 && expRd1.size() == 0, "R2", "unanswered reads",
          expRd0.size() + expRd1.size(), 0);
    repeat (3) @(negedge clk);
    finish();
  end
endmodule